// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls one general-purpose I/O port of W pins (eight by default) for a small microcontroller. Three registers set the port's behaviour. The data register holds the values to drive. The direction register selects output (1) or input (0) for each pin. The pull-up register enables a weak pull-up on each pin. A simple register bus writes and reads these registers. It also has single-bit set and clear strobes, and these perform a read-modify-write of the data register.

On the pad side the block drives an output enable, an output value and a pull-up enable for each pin, and it receives the pin level of each pin. Pin levels pass through a two-flop synchronizer before any read or merge uses them. A read of an input bit returns this synchronized level. A read of an output bit returns the stored value. When the chip is in a stop or timer-only power state and the pin-state-select control is set, every pin is released to high impedance and the input path is forced to zero. Pull-ups stay in effect during this state.

The direction and pull-up registers clear on reset. The data register has no reset and keeps its value across a reset. Software must therefore load the data before it turns a pin into an output.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction and pull-up registers are all zero, so pad_oe and pad_pu are 0 and reads of address 1 and address 2 return 0.
- R2: Reset does not change the data register: a value written before reset is driven and read back unchanged once the pins are made outputs again.
- R3: For a bit with direction 1, pad_oe is 1, pad_out equals the stored data bit, and a read of address 0 returns the stored bit.
- R4: For a bit with direction 0, pad_oe and pad_out are 0. A write to address 0 still updates the stored bit, and that bit appears on the pin once the direction changes to 1.
- R5: For a bit with direction 0, a read of address 0 returns the pin level captured two rising edges earlier (two-flop synchronizer).
- R6: pad_pu of a bit is 1 exactly when its pull-up bit is 1 and the bit is not driven (pad_oe 0).
- R7: A bit_set or bit_clr strobe without bus_wr loads the data register with the stored value on output bits and with the synchronized pin level on input bits. It then sets (bit_set) or clears (bit_clr) the bit at bit_idx, and bit_set wins when both strobes are high.
- R8: While lp_mode and hiz_sel are both 1, pad_oe and pad_out are 0 for every bit whatever the direction register holds, and pad_pu follows the pull-up register.
- R9: While lp_mode and hiz_sel are both 1, the synchronized input reads as 0, both in reads of input bits and in read-modify-write merges. With only one of the two high, the port works normally.
- R10: bus_rdata is 0 when bus_rd is low or when address 3 is read. Address 1 returns the direction register and address 2 returns the pull-up register.
- R11: bus_wr writes bus_wdata into the register at bus_addr (0 data, 1 direction, 2 pull-up). A write to address 3 changes nothing, and bus_wr takes priority over the bit strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | W | Write data |
| bus_rd | input | 1 | Read strobe; data valid in the same cycle |
| bus_rdata | output | W | Read data |
| bit_set | input | 1 | Read-modify-write set of one data bit |
| bit_clr | input | 1 | Read-modify-write clear of one data bit |
| bit_idx | input | log2(W) | Bit targeted by bit_set or bit_clr |
| lp_mode | input | 1 | Stop or timer-only power state active |
| hiz_sel | input | 1 | Pin-state-select: release pins in the power state |
| pad_in | input | W | Pin levels |
| pad_oe | output | W | Output enable for each pin |
| pad_out | output | W | Output value for each pin |
| pad_pu | output | W | Pull-up enable for each pin |

## Verification
Some properties are checked by assertions on every cycle. The direction and pull-up registers change only on their own writes. After each bit operation, output bits other than the target keep their value, input bits take the synchronized level, and the target bit ends in the commanded state. Reads of input bits return zero during the power override, and the read bus is idle when no read is strobed. Other behaviours can only be shown by the bench's scenarios: that the data register survives a reset, the two-edge latency from pin to read, the interplay of pull-ups with the external pin level, and the resumption of input sampling after the power state ends.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_PULL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sample_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= pin_i & ~{W{gate}};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sample_o = stage_q[STAGES-1] & ~{W{gate}};
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W    = 8,
  parameter int IDXW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  reg_sel_e        addr,
  input  logic [W-1:0]    wdata,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic [IDXW-1:0] idx,
  input  logic [W-1:0]    sample,
  output logic [W-1:0]    data_o,
  output logic [W-1:0]    dir_o,
  output logic [W-1:0]    pu_o,
  output logic            rmw_go
);
  logic [W-1:0] data_q, dir_q, pu_q;
  logic [W-1:0] bit_mask;

  function automatic logic [W-1:0] merge_view(input logic [W-1:0] stored,
                                              input logic [W-1:0] dir,
                                              input logic [W-1:0] pin);
    return (stored & dir) | (pin & ~dir);
  endfunction

  function automatic logic [W-1:0] one_hot(input logic [IDXW-1:0] i);
    return {{(W-1){1'b0}}, 1'b1} << i;
  endfunction

  assign bit_mask = one_hot(idx);
  assign rmw_go   = (set_i | clr_i) & ~wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      pu_q  <= '0;
    end else if (wr) begin
      if (addr == REG_DIR)  dir_q <= wdata;
      if (addr == REG_PULL) pu_q  <= wdata;
    end
  end

  // data register intentionally has no reset
  always_ff @(posedge clk) begin
    if (wr) begin
      if (addr == REG_DATA) data_q <= wdata;
    end else if (set_i) begin
      data_q <= merge_view(data_q, dir_q, sample) | bit_mask;
    end else if (clr_i) begin
      data_q <= merge_view(data_q, dir_q, sample) & ~bit_mask;
    end
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
  assign pu_o   = pu_q;

  a_r11_dir_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == REG_DIR) |=> $stable(dir_q));
  a_r11_pull_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == REG_PULL) |=> $stable(pu_q));
  a_r7_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_go && set_i) |=> data_q[$past(idx)]);
  a_r7_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_go && !set_i) |=> !data_q[$past(idx)]);
  a_r7_outputs_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_go |=> ((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(bit_mask)) == '0);
  a_r7_inputs_copied: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_go |=> ((data_q ^ $past(sample)) & ~$past(dir_q) & ~$past(bit_mask)) == '0);
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rd,
  input  reg_sel_e     addr,
  input  logic [W-1:0] data,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] pu,
  input  logic [W-1:0] sample,
  output logic [W-1:0] rdata
);
  function automatic logic [W-1:0] data_view(input logic [W-1:0] stored,
                                             input logic [W-1:0] d,
                                             input logic [W-1:0] pin);
    return (stored & d) | (pin & ~d);
  endfunction

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        REG_DATA: rdata = data_view(data, dir, sample);
        REG_DIR:  rdata = dir;
        REG_PULL: rdata = pu;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int W    = 8,
  parameter int IDXW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      bus_addr,
  input  logic            bus_wr,
  input  logic [W-1:0]    bus_wdata,
  input  logic            bus_rd,
  output logic [W-1:0]    bus_rdata,
  input  logic            bit_set,
  input  logic            bit_clr,
  input  logic [IDXW-1:0] bit_idx,
  input  logic            lp_mode,
  input  logic            hiz_sel,
  input  logic [W-1:0]    pad_in,
  output logic [W-1:0]    pad_oe,
  output logic [W-1:0]    pad_out,
  output logic [W-1:0]    pad_pu
);
  logic         lp_override;
  logic [W-1:0] sample;
  logic [W-1:0] data_q, dir_q, pu_q;
  logic         rmw_go;
  reg_sel_e     addr_e;

  assign lp_override = lp_mode & hiz_sel;
  assign addr_e      = reg_sel_e'(bus_addr);

  gpio_in_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .gate(lp_override),
    .pin_i(pad_in), .sample_o(sample)
  );

  gpio_regs #(.W(W), .IDXW(IDXW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(addr_e), .wdata(bus_wdata),
    .set_i(bit_set), .clr_i(bit_clr), .idx(bit_idx), .sample(sample),
    .data_o(data_q), .dir_o(dir_q), .pu_o(pu_q), .rmw_go(rmw_go)
  );

  gpio_rd_mux #(.W(W)) u_rd (
    .rd(bus_rd), .addr(addr_e), .data(data_q), .dir(dir_q), .pu(pu_q),
    .sample(sample), .rdata(bus_rdata)
  );

  assign pad_oe  = dir_q & ~{W{lp_override}};
  assign pad_out = data_q & pad_oe;
  assign pad_pu  = pu_q & ~pad_oe;

  a_r9_lp_inputs_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_override && bus_rd && addr_e == REG_DATA) |-> (bus_rdata & ~dir_q) == '0);
  a_r9_lp_merge_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_override && rmw_go) |=> (data_q & ~$past(dir_q) & ~({{(W-1){1'b0}}, 1'b1} << $past(bit_idx))) == '0);
  a_r10_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);
  a_r8_lp_pull_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lp_override |-> pad_pu == pu_q);
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int W = 8;
  localparam int IDXW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0, bit_set = 0, bit_clr = 0, lp_mode = 0, hiz_sel = 0;
  logic [W-1:0] bus_wdata = '0, pad_in = '0;
  logic [IDXW-1:0] bit_idx = '0;
  logic [W-1:0] bus_rdata, pad_oe, pad_out, pad_pu;

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] m_data = '0, m_dir = '0, m_pu = '0, m_s1 = '0, m_s2 = '0;

  always #4 clk = ~clk;

  gpio_port #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bit_set(bit_set), .bit_clr(bit_clr), .bit_idx(bit_idx),
    .lp_mode(lp_mode), .hiz_sel(hiz_sel), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  function automatic logic [W-1:0] exp_oe(input logic lp, input logic sel);
    return (lp && sel) ? '0 : m_dir;
  endfunction

  function automatic logic [W-1:0] pin_level(input logic [W-1:0] oe, input logic [W-1:0] ext);
    logic [W-1:0] lvl;
    for (int b = 0; b < W; b++)
      lvl[b] = oe[b] ? m_data[b] : (m_pu[b] ? 1'b1 : ext[b]);
    return lvl;
  endfunction

  function automatic logic [W-1:0] exp_read(input logic [1:0] a, input logic ovr);
    logic [W-1:0] seen;
    seen = ovr ? '0 : m_s2;
    case (a)
      2'd0: return (m_data & m_dir) | (seen & ~m_dir);
      2'd1: return m_dir;
      2'd2: return m_pu;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(input string tag, input logic wr, input logic rd, input logic [1:0] a,
                       input logic [W-1:0] wd, input logic st, input logic cl,
                       input logic [IDXW-1:0] ix, input logic lp, input logic sel,
                       input logic [W-1:0] ext);
    logic ovr;
    logic [W-1:0] oe, pin, base, msk, n_data, n_dir, n_pu;
    ovr = lp & sel;
    oe = exp_oe(lp, sel);
    pin = pin_level(oe, ext);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    bit_set = st; bit_clr = cl; bit_idx = ix; lp_mode = lp; hiz_sel = sel;
    pad_in = pin;
    #1;
    chk(tag, "pad_oe", pad_oe, oe);
    chk(tag, "pad_out", pad_out, m_data & oe);
    chk(tag, "pad_pu", pad_pu, m_pu & ~oe);
    chk(tag, "rdata", bus_rdata, rd ? exp_read(a, ovr) : '0);
    n_data = m_data; n_dir = m_dir; n_pu = m_pu;
    msk = W'(1) << ix;
    if (wr) begin
      if (a == 2'd0) n_data = wd;
      if (a == 2'd1) n_dir = wd;
      if (a == 2'd2) n_pu = wd;
    end else if (st || cl) begin
      base = (m_data & m_dir) | ((ovr ? '0 : m_s2) & ~m_dir);
      n_data = st ? (base | msk) : (base & ~msk);
    end
    @(posedge clk);
    m_s2 = m_s1;
    m_s1 = pin & ~{W{ovr}};
    m_data = n_data; m_dir = n_dir; m_pu = n_pu;
    @(negedge clk);
  endtask

  task automatic wr_reg(input string tag, input logic [1:0] a, input logic [W-1:0] v, input logic [W-1:0] ext);
    cycle(tag, 1, 0, a, v, 0, 0, 0, 0, 0, ext);
  endtask

  task automatic rd_reg(input string tag, input logic [1:0] a, input logic [W-1:0] ext,
                        input logic lp, input logic sel);
    cycle(tag, 0, 1, a, '0, 0, 0, 0, lp, sel, ext);
  endtask

  task automatic idle(input string tag, input int n, input logic [W-1:0] ext, input logic lp, input logic sel);
    for (int i = 0; i < n; i++) cycle(tag, 0, 0, 0, '0, 0, 0, 0, lp, sel, ext);
  endtask

  task automatic do_reset();
    bus_wr = 0; bus_rd = 0; bit_set = 0; bit_clr = 0; lp_mode = 0; hiz_sel = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    m_dir = '0; m_pu = '0; m_s1 = '0; m_s2 = '0;
    pad_in = '0;
    rst_n = 1;
    @(negedge clk);
    m_s2 = m_s1; m_s1 = '0;
  endtask

  initial begin
    #(8 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1: reset state
    chk("R1", "oe after reset", pad_oe, '0);
    chk("R1", "pu after reset", pad_pu, '0);
    rd_reg("R1", 2'd1, 8'h00, 0, 0);
    rd_reg("R1", 2'd2, 8'h00, 0, 0);

    // R4: input bits store but do not drive
    wr_reg("R4", 2'd0, 8'h3C, 8'h00);
    idle("R4", 1, 8'h00, 0, 0);
    wr_reg("R4", 2'd1, 8'hFF, 8'h00);
    chk("R4", "driven after dir", pad_out, 8'h3C);
    rd_reg("R3", 2'd0, 8'h00, 0, 0);

    // R2: data survives reset
    wr_reg("R2", 2'd0, 8'hA5, 8'h00);
    do_reset();
    wr_reg("R2", 2'd1, 8'hFF, 8'h00);
    chk("R2", "data kept", pad_out, 8'hA5);
    rd_reg("R2", 2'd0, 8'h00, 0, 0);

    // R5: synchronizer latency on input reads
    wr_reg("R5", 2'd1, 8'h00, 8'h5A);
    rd_reg("R5", 2'd0, 8'h5A, 0, 0);
    rd_reg("R5", 2'd0, 8'h5A, 0, 0);
    chk("R5", "pin after two edges", bus_rdata, 8'h5A);
    rd_reg("R5", 2'd0, 8'hC3, 0, 0);

    // R6: pull-ups on undriven bits
    wr_reg("R6", 2'd2, 8'hF0, 8'h00);
    wr_reg("R6", 2'd1, 8'h3C, 8'h00);
    chk("R6", "pull undriven only", pad_pu, 8'hC0);
    idle("R6", 2, 8'h00, 0, 0);
    rd_reg("R6", 2'd0, 8'h00, 0, 0);

    // R7: read-modify-write merge
    wr_reg("R7", 2'd2, 8'h00, 8'hF0);
    wr_reg("R7", 2'd1, 8'h0F, 8'hF0);
    wr_reg("R7", 2'd0, 8'h00, 8'hF0);
    idle("R7", 2, 8'hF0, 0, 0);
    cycle("R7", 0, 0, 0, '0, 1, 0, 3'd1, 0, 0, 8'hF0);
    wr_reg("R7", 2'd1, 8'hFF, 8'h00);
    chk("R7", "merged data", pad_out, 8'hF2);
    cycle("R7", 0, 0, 0, '0, 1, 1, 3'd6, 0, 0, 8'h00);
    chk("R7", "set wins", pad_out[6], 1'b1);
    cycle("R7", 0, 0, 0, '0, 0, 1, 3'd1, 0, 0, 8'h00);
    chk("R7", "clear bit1", pad_out, 8'hF0);
    cycle("R11", 1, 0, 2'd0, 8'h11, 1, 0, 3'd7, 0, 0, 8'h00);
    chk("R11", "write beats set", pad_out, 8'h11);
    cycle("R11", 1, 0, 2'd3, 8'hEE, 0, 0, 3'd0, 0, 0, 8'h00);
    rd_reg("R11", 2'd1, 8'h00, 0, 0);
    rd_reg("R10", 2'd3, 8'h00, 0, 0);

    // R8 / R9: low-power override
    wr_reg("R8", 2'd2, 8'h0F, 8'hAA);
    wr_reg("R8", 2'd1, 8'hF0, 8'hAA);
    idle("R8", 2, 8'hAA, 1, 0);
    rd_reg("R9", 2'd0, 8'hAA, 1, 0);
    idle("R8", 1, 8'hAA, 1, 1);
    chk("R8", "no drive in lp", pad_oe, '0);
    chk("R8", "pull kept in lp", pad_pu, 8'h0F);
    rd_reg("R9", 2'd0, 8'hAA, 1, 1);
    cycle("R9", 0, 0, 0, '0, 1, 0, 3'd7, 1, 1, 8'hAA);
    idle("R9", 3, 8'hAA, 0, 0);
    rd_reg("R9", 2'd0, 8'hAA, 0, 0);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [1:0] a; logic wr, rd, st, cl, lp, sel;
      a   = 2'($urandom_range(0, 3));
      wr  = ($urandom_range(0, 9) < 3);
      rd  = ($urandom_range(0, 1) == 1);
      st  = ($urandom_range(0, 9) == 0);
      cl  = ($urandom_range(0, 9) == 0);
      lp  = ($urandom_range(0, 9) < 2);
      sel = ($urandom_range(0, 1) == 1);
      cycle("R3 R4 R5 R6 R7 R8 R9 R10 R11", wr, rd, a, 8'($urandom),
            st, cl, 3'($urandom_range(0, 7)), lp, sel, 8'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule